// File: doc/BRIEF.md
# Head-Settle and Drive-Ready Timer

This block produces two qualifiers that a floppy-disk controller core waits on before it moves data. The first, `hlt`, reports that the read/write head has had time to settle: it stays low for a fixed window, nominally 40 ms, after the head-load request is raised, and it goes high only when that window has elapsed with the request still present. The window length is a cycle count derived from the clock frequency and the settle time in microseconds.

The second, `rdy`, tells the core that the selected drive is spinning. A standard drive provides its own ready line, which is passed straight to `rdy`. A mini drive has no such line, so the block counts disk revolutions: each rising edge of the index input, after a two-flop synchronizer, adds one. `rdy` rises when the count reaches a target chosen by a two-bit select, from five to eight revolutions. Once reached, it holds until reset or until a new drive is selected.

The settle part is a three-state machine: IDLE (no request), WAIT (window running) and DONE (window elapsed). Its transitions are IDLE to WAIT when the request is seen high, WAIT to DONE on the last window cycle, and WAIT or DONE back to IDLE when the request drops. The ready part has two states: COUNT and READY. COUNT goes to READY on the index edge that meets the target. Either state returns to COUNT, with the count cleared, when a selection change is seen.

Top module: `settle_ready_timer`

## Requirements
- R1: After reset `hlt` is 0. When `head_load` is first sampled high from IDLE, `hlt` stays 0 for SETTLE_CYCLES clock edges, counting that edge. It becomes 1 after the next edge. SETTLE_CYCLES = CLK_HZ/1_000_000 × SETTLE_US.
- R2: After the window, `hlt` stays 1 for as long as `head_load` stays high.
- R3: When `head_load` goes low, `hlt` goes to 0 in the same cycle and the window is abandoned. Raising `head_load` again starts a full new window.
- R4: With `mini_mode`=1, `rdy` rises after the counted index edge that reaches the target. The target is set by `rev_sel`: 2'b00 selects 6 revolutions, 2'b01 selects 5, 2'b10 selects 7 and 2'b11 selects 8.
- R5: An index edge is counted only on a low-to-high change of the synchronized input. A high level lasting many cycles counts once.
- R6: `sel_change` high at a clock edge clears the revolution count and, in mini mode, drops `rdy` from that edge on. Counting then starts again from zero.
- R7: Once `rdy` is reached in mini mode, it holds through any further index pulses until reset or a selection change.
- R8: With `mini_mode`=0, `rdy` equals `drive_rdy_in` in the same cycle, whatever the index input does.
- R9: Reset clears the revolution count, so `rdy` is 0 in mini mode after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| head_load | input | 1 | Head-load request from the controller core |
| index_raw | input | 1 | Index pulse from the drive, asynchronous |
| sel_change | input | 1 | One-cycle strobe: drive selection or door changed |
| mini_mode | input | 1 | 1 selects a mini drive (synthesised ready) |
| drive_rdy_in | input | 1 | Ready line supplied by a standard drive |
| rev_sel | input | 2 | Revolution target select (see R4) |
| hlt | output | 1 | Head settled qualifier |
| rdy | output | 1 | Drive ready qualifier |

## Verification
The assertions assume that `head_load`, `sel_change`, `mini_mode` and `rev_sel` are synchronous to `clk`. They also assume that `sel_change` is a strobe, not a level held across many index edges. The bench changes all of these inputs only at the falling clock edge. It holds `rev_sel` steady while a count is running, and it keeps `index_raw` low across reset. Index pulses are at least two cycles high and several cycles low, so every edge survives the synchronizer as one clean rise.

// File: rtl/srt_pkg.sv
package srt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_DONE = 2'd2
    } settle_state_t;

    typedef enum logic {
        RS_COUNT = 1'b0,
        RS_READY = 1'b1
    } ready_state_t;

endpackage

// File: rtl/srt_sync.sv
module srt_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              last_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= 1'b0;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= chain[STAGES-1];
    end

    assign rise = chain[STAGES-1] & ~last_q;

    // a rise lasts exactly one cycle
    AST_RISE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise); // R5
endmodule

// File: rtl/srt_settle.sv
module srt_settle
    import srt_pkg::*;
#(
    parameter int unsigned SETTLE_CYCLES = 640000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic head_load,
    output logic hlt
);
    localparam int unsigned CW = $clog2(SETTLE_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(SETTLE_CYCLES - 1);

    settle_state_t st, st_nx;
    logic [CW-1:0] cnt, cnt_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= ST_IDLE;
            cnt <= '0;
        end else begin
            st  <= st_nx;
            cnt <= cnt_nx;
        end
    end

    always_comb begin
        st_nx  = st;
        cnt_nx = cnt;
        unique case (st)
            ST_IDLE: begin
                cnt_nx = '0;
                if (head_load) st_nx = ST_WAIT;
            end
            ST_WAIT: begin
                if (!head_load) begin
                    st_nx  = ST_IDLE;
                    cnt_nx = '0;
                end else if (cnt == LAST) begin
                    st_nx  = ST_DONE;
                end else begin
                    cnt_nx = cnt + CW'(1);
                end
            end
            ST_DONE: begin
                if (!head_load) begin
                    st_nx  = ST_IDLE;
                    cnt_nx = '0;
                end
            end
            default: begin
                st_nx  = ST_IDLE;
                cnt_nx = '0;
            end
        endcase
    end

    always_comb begin
        hlt = 1'b0;
        unique case (st)
            ST_DONE: hlt = head_load;
            default: hlt = 1'b0;
        endcase
    end

    AST_REQ_STARTS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && head_load) |=> (st == ST_WAIT && cnt == '0)); // R1
    AST_WINDOW_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WAIT && head_load && cnt != LAST) |=> (st == ST_WAIT && cnt == $past(cnt) + CW'(1))); // R1
    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DONE && head_load) |=> (st == ST_DONE)); // R2
    AST_DROP_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
        !head_load |=> (st == ST_IDLE)); // R3
endmodule

// File: rtl/srt_ready.sv
module srt_ready
    import srt_pkg::*;
#(
    parameter int unsigned BASE_REVS = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rise,
    input  logic       sel_change,
    input  logic [1:0] rev_sel,
    output logic       rdy_mini
);
    localparam int unsigned MAX_REVS = BASE_REVS + 3;
    localparam int unsigned CW = $clog2(MAX_REVS + 1);

    ready_state_t  st, st_nx;
    logic [CW-1:0] cnt, cnt_nx;
    logic [CW-1:0] target;

    // 00 is the nominal setting, one above the base
    always_comb begin
        target = CW'(BASE_REVS + 1);
        unique case (rev_sel)
            2'b00: target = CW'(BASE_REVS + 1);
            2'b01: target = CW'(BASE_REVS);
            2'b10: target = CW'(BASE_REVS + 2);
            2'b11: target = CW'(BASE_REVS + 3);
            default: target = CW'(BASE_REVS + 1);
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= RS_COUNT;
            cnt <= '0;
        end else begin
            st  <= st_nx;
            cnt <= cnt_nx;
        end
    end

    always_comb begin
        st_nx  = st;
        cnt_nx = cnt;
        if (sel_change) begin
            st_nx  = RS_COUNT;
            cnt_nx = '0;
        end else begin
            unique case (st)
                RS_COUNT: begin
                    if (rise) begin
                        cnt_nx = cnt + CW'(1);
                        if ((cnt + CW'(1)) >= target) st_nx = RS_READY;
                    end
                end
                RS_READY: begin
                    cnt_nx = cnt;
                end
                default: begin
                    st_nx  = RS_COUNT;
                    cnt_nx = '0;
                end
            endcase
        end
    end

    always_comb begin
        rdy_mini = 1'b0;
        unique case (st)
            RS_READY: rdy_mini = 1'b1;
            default:  rdy_mini = 1'b0;
        endcase
    end

    AST_SEL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        sel_change |=> (st == RS_COUNT && cnt == '0)); // R6
    AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (st == RS_READY && !sel_change) |=> (st == RS_READY && $stable(cnt))); // R7
    AST_COUNT_ONLY_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == RS_COUNT && !rise && !sel_change) |=> $stable(cnt)); // R5
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(MAX_REVS)); // R7
endmodule

// File: rtl/settle_ready_timer.sv
module settle_ready_timer #(
    parameter int unsigned CLK_HZ      = 16_000_000,
    parameter int unsigned SETTLE_US   = 40_000,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned BASE_REVS   = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       head_load,
    input  logic       index_raw,
    input  logic       sel_change,
    input  logic       mini_mode,
    input  logic       drive_rdy_in,
    input  logic [1:0] rev_sel,
    output logic       hlt,
    output logic       rdy
);
    localparam int unsigned SETTLE_CYCLES = (CLK_HZ / 1_000_000) * SETTLE_US;

    logic idx_rise;
    logic rdy_mini;

    srt_settle #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
        .clk       (clk),
        .rst_n     (rst_n),
        .head_load (head_load),
        .hlt       (hlt)
    );

    srt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (index_raw),
        .rise  (idx_rise)
    );

    srt_ready #(.BASE_REVS(BASE_REVS)) u_ready (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise       (idx_rise),
        .sel_change (sel_change),
        .rev_sel    (rev_sel),
        .rdy_mini   (rdy_mini)
    );

    assign rdy = mini_mode ? rdy_mini : drive_rdy_in;

    AST_HLT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        hlt |-> $past(head_load)); // R1
endmodule

// File: tb/test_settle_ready_timer.sv
`timescale 1ns/1ps
module test_settle_ready_timer;
    localparam int unsigned N = 20; // 1 MHz x 20 us

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic head_load = 1'b0;
    logic index_raw = 1'b0;
    logic sel_change = 1'b0;
    logic mini_mode = 1'b1;
    logic drive_rdy_in = 1'b0;
    logic [1:0] rev_sel = 2'b00;
    logic hlt, rdy;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    settle_ready_timer #(.CLK_HZ(1_000_000), .SETTLE_US(N)) i_settle_ready_timer (
        .clk(clk), .rst_n(rst_n), .head_load(head_load), .index_raw(index_raw),
        .sel_change(sel_change), .mini_mode(mini_mode), .drive_rdy_in(drive_rdy_in),
        .rev_sel(rev_sel), .hlt(hlt), .rdy(rdy)
    );

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic pulse(input int hi);
        @(negedge clk) index_raw = 1'b1;
        repeat (hi) @(negedge clk);
        index_raw = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic strobe_sel();
        @(negedge clk) sel_change = 1'b1;
        @(negedge clk) sel_change = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(hlt, 1'b0, "R9 hlt after reset");
        chk(rdy, 1'b0, "R9 rdy after reset");
    endtask

    task automatic t_settle();
        @(negedge clk) head_load = 1'b1;
        repeat (N) @(posedge clk);
        @(negedge clk) chk(hlt, 1'b0, "R1 hlt low at window end");
        @(posedge clk);
        @(negedge clk) chk(hlt, 1'b1, "R1 hlt high after window");
        repeat (30) @(negedge clk);
        chk(hlt, 1'b1, "R2 hlt held");
    endtask

    task automatic t_drop();
        head_load = 1'b0;
        #0.5 chk(hlt, 1'b0, "R3 hlt drops same cycle");
        @(negedge clk) head_load = 1'b1;
        repeat (N - 5) @(negedge clk);
        head_load = 1'b0;
        @(negedge clk) head_load = 1'b1;
        repeat (N) @(posedge clk);
        @(negedge clk) chk(hlt, 1'b0, "R3 restarted window not early");
        @(posedge clk);
        @(negedge clk) chk(hlt, 1'b1, "R3 restarted window ends");
        head_load = 1'b0;
    endtask

    task automatic t_count(input logic [1:0] sel, input int revs);
        rev_sel = sel;
        strobe_sel();
        for (int i = 0; i < revs - 1; i++) pulse(2);
        chk(rdy, 1'b0, $sformatf("R4 not ready before %0d", revs));
        pulse(2);
        chk(rdy, 1'b1, $sformatf("R4 ready at %0d", revs));
    endtask

    task automatic t_long();
        rev_sel = 2'b01;
        strobe_sel();
        for (int i = 0; i < 3; i++) pulse(2);
        pulse(25);
        chk(rdy, 1'b0, "R5 long pulse counts once");
        pulse(2);
        chk(rdy, 1'b1, "R5 fifth edge reaches ready");
    endtask

    task automatic t_hold_and_sel();
        for (int i = 0; i < 12; i++) pulse(2);
        chk(rdy, 1'b1, "R7 ready held over extra pulses");
        strobe_sel();
        chk(rdy, 1'b0, "R6 selection change drops rdy");
        rev_sel = 2'b00;
        for (int i = 0; i < 5; i++) pulse(2);
        chk(rdy, 1'b0, "R6 count restarted from zero");
        pulse(2);
        chk(rdy, 1'b1, "R6 ready after full recount");
    endtask

    task automatic t_standard();
        mini_mode = 1'b0;
        drive_rdy_in = 1'b0;
        #0.5 chk(rdy, 1'b0, "R8 pass-through low");
        for (int i = 0; i < 8; i++) pulse(2);
        chk(rdy, 1'b0, "R8 index ignored");
        drive_rdy_in = 1'b1;
        #0.5 chk(rdy, 1'b1, "R8 pass-through high");
        @(negedge clk) drive_rdy_in = 1'b0;
        #0.5 chk(rdy, 1'b0, "R8 pass-through falls");
        mini_mode = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_settle();
        t_drop();
        t_count(2'b00, 6);
        t_count(2'b01, 5);
        t_count(2'b10, 7);
        t_count(2'b11, 8);
        t_long();
        t_hold_and_sel();
        t_standard();
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) chk(rdy, 1'b0, "R9 reset clears ready");
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end
endmodule